// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the serial test port of a memory device. A sixteen-state controller follows the mode-select line on each rising edge of the test clock. The controller selects one of two paths between the serial input and the serial output. The first path is a 3-bit instruction register. The second path is one of three data registers: a single bypass stage, a fixed 32-bit identification word, or a boundary chain of `BSR_LEN` cells. Serial data enters at the most significant end and leaves from the least significant end. The serial output changes on the falling edge of the clock. It is enabled only while a register is being shifted.

The boundary chain has a shift stage and a separate update stage. The shift stage loads the parallel pin values given on `bnd_cap`. The update stage drives `bnd_upd` toward the pad logic. Cell `OE_CELL` has no pin behind it. It holds the output enable of the read data bus while external test is active. The block also produces three controls for the functional outputs:
- `extest_sel` shows that the pads are driven from the update stage.
- `extest_oe` gates the read data bus during external test.
- `force_hiz` sends every functional output to high impedance.

The port is a plain serial interface with no handshake. Each bit is accepted on the rising edge that samples it, and no back-pressure exists.

Top module: `scan_port_ctl`

## Requirements
- R1: TMS and TDI are sampled on the rising edge of `tck`. `tdo` and `tdo_en` change only on the falling edge. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R2: From any state, five consecutive rising edges with `tms` = 1 bring the controller to Test-Logic-Reset.
- R3: After `por_n` is released, and after Test-Logic-Reset, the active instruction is IDCODE. In both cases `force_hiz` = 0 and `extest_sel` = 0.
- R4: Capture-IR loads binary 001 into the instruction shift stage. The bits therefore leave `tdo` in the order 1, 0, 0.
- R5: IDCODE (code 001) selects a 32-bit register. It captures {revision[2:0], part[16:0], maker[10:0], 1'b1}, with the revision in bits 31:29 and bit 0 always 1, and shifts it out LSB first.
- R6: BYPASS (code 111) selects one stage that captures 0, so the data on `tdo` is TDI delayed by one bit. The reserved codes 011, 101 and 110 behave the same way.
- R7: SAMPLE/PRELOAD (code 100) selects the boundary chain. In Capture-DR, cell i loads `bnd_cap[i]`, except cell `OE_CELL`, which loads its own update value. Update-DR copies the chain into `bnd_upd`. `extest_sel` and `extest_oe` stay 0 under this instruction.
- R8: EXTEST (code 000) sets `extest_sel` = 1 and `extest_oe` = `bnd_upd[OE_CELL]` (1 drives the bus, 0 gives high impedance). The boundary chain is selected.
- R9: SAMPLE Z (code 010) selects the boundary chain. It holds `force_hiz` = 1 from its Update-IR until another instruction is updated.
- R10: `bnd_upd` changes only in Update-DR under a boundary instruction. Capture, shift, pause and instruction updates leave it unchanged. The one exception is the preset of R11.
- R11: `bnd_upd[OE_CELL]` is preset to 1 by `por_n` and in Test-Logic-Reset. All other update cells reset to 0 on `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| bnd_cap | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | Output enable of `tdo`, high only while shifting |
| bnd_upd | output | BSR_LEN | Update stage of the boundary chain |
| extest_sel | output | 1 | EXTEST active: pads follow `bnd_upd` |
| extest_oe | output | 1 | Read bus enable under EXTEST (1 drive, 0 high impedance) |
| force_hiz | output | 1 | SAMPLE Z active: all functional outputs high impedance |

## Verification
Three kinds of result have different timing:
- A captured bit appears on `tdo` at the falling edge after the rising edge that enters a shift state.
- A new instruction takes effect on the rising edge that leaves Update-IR.
- `bnd_upd` changes on the rising edge that leaves Update-DR.

The bench drives TMS and TDI just after a falling edge and samples every output 1 ns after the next falling edge. Each sample therefore sees exactly one rising-edge step and the following falling-edge update. Instruction controls are checked once the controller is back in Run-Test/Idle. To show that nothing moves before Update-DR, the chain is parked in Pause-DR and checked there before the scan is completed.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_st_e;

  localparam int unsigned IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXT  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDC  = 3'b001;
  localparam logic [IR_W-1:0] OP_SMPZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SMP  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYP  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAP  = 3'b001;

  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_ID  = 2'd1,
    SEL_BND = 2'd2
  } dr_sel_e;

  function automatic dr_sel_e op_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_EXT, OP_SMPZ, OP_SMP: op_decode = SEL_BND;
      OP_IDC:                  op_decode = SEL_ID;
      default:                 op_decode = SEL_BYP;
    endcase
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic    tck,
  input  logic    por_n,
  input  logic    tms,
  output tap_st_e st
);

  tap_st_e nxt;

  always_comb begin
    case (st)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) st <= ST_TLR;
    else        st <= nxt;
  end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_st_e         st,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr <= IR_CAP;
    end else if (st == ST_CAP_IR) begin
      ir_sr <= IR_CAP;
    end else if (st == ST_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 ir_q <= OP_IDC;
    else if (st == ST_TLR)      ir_q <= OP_IDC;
    else if (st == ST_UPD_IR)   ir_q <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int unsigned BSR_LEN = 107,
  parameter int unsigned OE_CELL = 47,
  parameter logic [31:0] ID_WORD = 32'h1
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tdi,
  input  tap_st_e            st,
  input  dr_sel_e            sel,
  input  logic [BSR_LEN-1:0] bnd_cap,
  output logic [BSR_LEN-1:0] bnd_upd,
  output logic               dr_lsb
);

  localparam logic [BSR_LEN-1:0] UPD_RST = BSR_LEN'(1) << OE_CELL;

  logic               byp_q;
  logic [31:0]        id_sr;
  logic [BSR_LEN-1:0] bnd_sr;
  logic [BSR_LEN-1:0] cap_vec;
  logic               cap_en, sh_en;

  assign cap_en = (st == ST_CAP_DR);
  assign sh_en  = (st == ST_SH_DR);

  // Each cell loads its pin, except the internal enable cell, which
  // loads its own update value.
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cap
    if (i == OE_CELL) begin : g_int
      assign cap_vec[i] = bnd_upd[i];
    end else begin : g_pin
      assign cap_vec[i] = bnd_cap[i];
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q <= 1'b0;
    end else if (sel == SEL_BYP) begin
      if (cap_en)     byp_q <= 1'b0;
      else if (sh_en) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      id_sr <= ID_WORD;
    end else if (sel == SEL_ID) begin
      if (cap_en)     id_sr <= ID_WORD;
      else if (sh_en) id_sr <= {tdi, id_sr[31:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      bnd_sr <= '0;
    end else if (sel == SEL_BND) begin
      if (cap_en)     bnd_sr <= cap_vec;
      else if (sh_en) bnd_sr <= {tdi, bnd_sr[BSR_LEN-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      bnd_upd <= UPD_RST;
    end else if (st == ST_TLR) begin
      bnd_upd[OE_CELL] <= 1'b1;
    end else if (st == ST_UPD_DR && sel == SEL_BND) begin
      bnd_upd <= bnd_sr;
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:  dr_lsb = id_sr[0];
      SEL_BND: dr_lsb = bnd_sr[0];
      default: dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_port_ctl.sv
module scan_port_ctl
  import scan_pkg::*;
#(
  parameter int unsigned BSR_LEN  = 107,
  parameter int unsigned OE_CELL  = 47,
  parameter logic [2:0]  REV_ID   = 3'd2,
  parameter logic [16:0] PART_ID  = 17'h1A5C3,
  parameter logic [10:0] MAKER_ID = 11'h034
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bnd_cap,
  output logic               tdo,
  output logic               tdo_en,
  output logic [BSR_LEN-1:0] bnd_upd,
  output logic               extest_sel,
  output logic               extest_oe,
  output logic               force_hiz
);

  localparam logic [31:0] ID_WORD = {REV_ID, PART_ID, MAKER_ID, 1'b1};

  tap_st_e         cur_st;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  dr_sel_e         sel;

  scan_fsm u_fsm (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .st    (cur_st)
  );

  scan_ir u_ir (
    .tck    (tck),
    .por_n  (por_n),
    .tdi    (tdi),
    .st     (cur_st),
    .ir_q   (ir_q),
    .ir_lsb (ir_lsb)
  );

  assign sel = op_decode(ir_q);

  scan_dr #(
    .BSR_LEN (BSR_LEN),
    .OE_CELL (OE_CELL),
    .ID_WORD (ID_WORD)
  ) u_dr (
    .tck     (tck),
    .por_n   (por_n),
    .tdi     (tdi),
    .st      (cur_st),
    .sel     (sel),
    .bnd_cap (bnd_cap),
    .bnd_upd (bnd_upd),
    .dr_lsb  (dr_lsb)
  );

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (cur_st == ST_SH_IR) ? ir_lsb : dr_lsb;
      tdo_en <= (cur_st == ST_SH_IR) || (cur_st == ST_SH_DR);
    end
  end

  assign extest_sel = (ir_q == OP_EXT);
  assign extest_oe  = extest_sel & bnd_upd[OE_CELL];
  assign force_hiz  = (ir_q == OP_SMPZ);

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
#(
  parameter int unsigned BSR_LEN = 107,
  parameter int unsigned OE_CELL = 47
) (
  input logic               tck,
  input logic               por_n,
  input logic               tms,
  input logic               tdo_en,
  input logic               force_hiz,
  input logic [BSR_LEN-1:0] bnd_upd,
  input tap_st_e            cur_st,
  input logic [IR_W-1:0]    ir_q
);

  logic [2:0] ones_q;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)           ones_q <= '0;
    else if (!tms)        ones_q <= '0;
    else if (ones_q != 5) ones_q <= ones_q + 3'd1;
  end

  a_r1_tdo_en_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en == (cur_st == ST_SH_IR || cur_st == ST_SH_DR));

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q == 3'd5) |-> (cur_st == ST_TLR));

  a_r3_ir_idcode_tlr: assert property (@(posedge tck) disable iff (!por_n)
    (cur_st == ST_TLR) |=> (ir_q == OP_IDC));

  a_r9_hiz_from_update: assert property (@(posedge tck) disable iff (!por_n)
    $rose(force_hiz) |-> ($past(cur_st) == ST_UPD_IR));

  a_r10_upd_stable: assert property (@(posedge tck) disable iff (!por_n)
    (cur_st != ST_UPD_DR && cur_st != ST_TLR) |=> $stable(bnd_upd));

  a_r11_oe_preset: assert property (@(posedge tck) disable iff (!por_n)
    (cur_st == ST_TLR) |=> bnd_upd[OE_CELL]);

endmodule

bind scan_port_ctl scan_port_chk #(
  .BSR_LEN (BSR_LEN),
  .OE_CELL (OE_CELL)
) u_chk (
  .tck       (tck),
  .por_n     (por_n),
  .tms       (tms),
  .tdo_en    (tdo_en),
  .force_hiz (force_hiz),
  .bnd_upd   (bnd_upd),
  .cur_st    (cur_st),
  .ir_q      (ir_q)
);

// File: tb/test_scan_port_ctl.sv
`timescale 1ns/1ps
module test_scan_port_ctl;

  localparam int BL = 107;
  localparam int OE = 47;
  localparam logic [31:0] EXP_ID = {3'd2, 17'h1A5C3, 11'h034, 1'b1};

  logic          tck = 1'b0;
  logic          por_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [BL-1:0] bnd_cap = '0;
  logic          tdo, tdo_en, extest_sel, extest_oe, force_hiz;
  logic [BL-1:0] bnd_upd;

  int total = 0;
  int bad = 0;
  logic en_all;

  always #5 tck = ~tck;

  scan_port_ctl i_scan_port_ctl (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .bnd_cap(bnd_cap),
    .tdo(tdo), .tdo_en(tdo_en), .bnd_upd(bnd_upd),
    .extest_sel(extest_sel), .extest_oe(extest_oe), .force_hiz(force_hiz)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // From Run-Test/Idle through a full IR scan back to Run-Test/Idle.
  task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    en_all = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      en_all &= tdo_en;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    en_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      en_all &= tdo_en;
      step(i == n - 1, din[i]);
    end
    chk("R1 tdo_en low after shift", {127'd0, tdo_en}, 128'd0);
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] v = '0;
    for (int i = 0; i < BL; i++) v[i] = (((i * 7 + seed) % 5) < 2);
    return v;
  endfunction

  task automatic t_reset;
    chk("R1 tdo_en at reset", {127'd0, tdo_en}, 128'd0);
    chk("R3 force_hiz at reset", {127'd0, force_hiz}, 128'd0);
    chk("R3 extest_sel at reset", {127'd0, extest_sel}, 128'd0);
    chk("R11 update stage at reset", {21'd0, bnd_upd}, 128'd1 << OE);
    step(0, 0);
  endtask

  task automatic t_idcode;
    logic [127:0] d;
    dr_scan(32, 128'd0, d);
    chk("R5 idcode readout", d, {96'd0, EXP_ID});
    chk("R1 tdo_en during shift", {127'd0, en_all}, 128'd1);
  endtask

  task automatic t_bypass;
    logic [2:0] c;
    logic [127:0] d;
    ir_scan(3'b111, c);
    chk("R4 capture-IR value", {125'd0, c}, 128'd1);
    chk("R1 tdo_en during IR shift", {127'd0, en_all}, 128'd1);
    dr_scan(16, 128'hA5C3, d);
    chk("R6 bypass one-bit delay", d, {112'd0, 16'hA5C3 << 1});
  endtask

  task automatic t_reserved;
    logic [2:0] c;
    logic [127:0] d;
    logic [2:0] codes [3] = '{3'b011, 3'b101, 3'b110};
    foreach (codes[k]) begin
      ir_scan(codes[k], c);
      dr_scan(8, 128'hB4, d);
      chk("R6 reserved code acts as bypass", d, {120'd0, 8'h68});
      chk("R6 reserved code no hiz", {127'd0, force_hiz}, 128'd0);
    end
  endtask

  task automatic t_sample;
    logic [2:0] c;
    logic [127:0] d, p, q, e;
    p = pat(3);
    q = pat(1);
    q[OE] = 1'b0;
    bnd_cap = p[BL-1:0];
    ir_scan(3'b100, c);
    dr_scan(BL, q, d);
    e = p;
    e[OE] = 1'b1;
    chk("R7 sample capture", d, e);
    chk("R7 preload into update stage", {21'd0, bnd_upd}, q);
    chk("R7 no extest under sample", {126'd0, extest_sel, extest_oe}, 128'd0);
  endtask

  task automatic t_extest;
    logic [2:0] c;
    logic [127:0] q, r;
    q = pat(1);
    q[OE] = 1'b0;
    r = ~q;
    r[127:BL] = '0;
    ir_scan(3'b000, c);
    chk("R8 extest selected", {127'd0, extest_sel}, 128'd1);
    chk("R8 extest_oe follows cell low", {127'd0, extest_oe}, 128'd0);
    chk("R10 IR update keeps update stage", {21'd0, bnd_upd}, q);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < BL; i++) step(i == BL - 1, r[i]);
    step(0, 0);
    chk("R10 update stage held in pause", {21'd0, bnd_upd}, q);
    step(1, 0); step(1, 0); step(0, 0);
    chk("R10 update stage after Update-DR", {21'd0, bnd_upd}, r);
    chk("R8 extest_oe follows cell high", {127'd0, extest_oe}, 128'd1);
  endtask

  task automatic t_samplez;
    logic [2:0] c;
    logic [127:0] d, e;
    ir_scan(3'b010, c);
    chk("R9 force_hiz on", {127'd0, force_hiz}, 128'd1);
    chk("R9 no extest under sample z", {127'd0, extest_sel}, 128'd0);
    dr_scan(BL, 128'd0, d);
    e = pat(3);
    e[OE] = 1'b1;
    chk("R9 boundary chain selected", d, e);
    chk("R9 force_hiz held over DR scan", {127'd0, force_hiz}, 128'd1);
    ir_scan(3'b001, c);
    chk("R9 force_hiz cleared by new instruction", {127'd0, force_hiz}, 128'd0);
  endtask

  task automatic t_tlr;
    logic [2:0] c;
    logic [127:0] d;
    ir_scan(3'b000, c);
    dr_scan(BL, 128'd0, d);
    chk("R8 extest_oe after zero preload", {127'd0, extest_oe}, 128'd0);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R2 tdo_en off after reset walk", {127'd0, tdo_en}, 128'd0);
    step(0, 0);
    chk("R3 extest cleared by TLR", {127'd0, extest_sel}, 128'd0);
    chk("R11 enable cell preset in TLR", {127'd0, bnd_upd[OE]}, 128'd1);
    dr_scan(32, 128'd0, d);
    chk("R2 idcode after five ones", d, {96'd0, EXP_ID});
    ir_scan(3'b111, c);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    dr_scan(32, 128'd0, d);
    chk("R3 IR reset from Shift-IR", d, {96'd0, EXP_ID});
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    #1;
    por_n = 1'b1;
    t_reset();
    t_idcode();
    t_bypass();
    t_reserved();
    t_sample();
    t_extest();
    t_samplez();
    t_tlr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule